// File: doc/BRIEF.md
# Double-Buffered Result Bank Controller

This block sits between a multiply-accumulate engine and a host processor. It holds two result banks of several bytes each. One bank, called the compute bank, takes each finished result from the engine. The other bank, called the host bank, is the one the host reads through a small window of byte registers. Each bank carries a two-state status, empty or done. A status register reports both states.

The two banks trade roles in one of two ways. The host can write the status register when its own bank is empty and a result is waiting. The swap also happens on its own when the host reads the last byte of a result. The last byte is found by looking at the upper byte of the host read address. A block-input string loop places its remaining-transfer count on those lines, so the loop can drain the window in one instruction.

The roles are swapped by flipping a select bit, not by copying the bank contents. An engine result that arrives while the compute bank still holds an unclaimed result is dropped, and the block raises an overrun pulse.

Top module: `rbc_result_banks`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both status fields read 00 (empty), `res_bytes` is all zero and `overrun` is low.
- R2: When `eng_valid` is high and the compute bank is empty, the result is stored in the compute bank and the compute status becomes 01 (done) on the next cycle. The host bank and `res_bytes` do not change.
- R3: A host write to status offset `STAT_OFS` swaps the banks when the host status is empty and the compute status is done. On the next cycle the host status is 01, the compute status is 00, and `res_bytes` shows the result that was waiting.
- R4: A status write under any other combination of states changes neither status field nor `res_bytes`.
- R5: A final read moves the host status from done to empty when the compute bank is empty. A final read is a read strobe whose low address byte is in the result window (`RES_OFS` to `RES_OFS+RES_BYTES-1`) and whose upper address bits equal `FINAL_TAG`. Reads with any other upper bits change no state.
- R6: A final read while both statuses are done swaps the banks. The host status stays 01, the compute status becomes 00, and `res_bytes` shows the newer result.
- R7: An engine result that arrives while the compute status is done, and no swap frees that bank in the same cycle, is discarded. `overrun` pulses high for exactly one cycle. If a swap frees the bank in that same cycle, the result is stored and no overrun is raised.
- R8: `host_rd_data` is combinational on the read address. Window offset i returns host-bank byte i, where byte 0 is bits 7:0. Offset `STAT_OFS` returns the host status code in bits 1:0 and the compute status code in bits 3:2, with all other bits zero. Any other offset returns zero.
- R9: A final read while the host status is empty changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eng_valid | input | 1 | Engine result-complete pulse |
| eng_result | input | RES_BYTES*BYTE_W | Finished result from the engine |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_ofs | input | 8 | Register offset of the host write |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_addr | input | ADDR_W | Full host read address; the upper bits carry the transfer tag |
| host_rd_data | output | BYTE_W | Read data for the addressed register |
| res_bytes | output | RES_BYTES*BYTE_W | Contents of the host bank |
| calc_stat | output | 2 | Compute bank status code |
| data_stat | output | 2 | Host bank status code |
| overrun | output | 1 | One-cycle pulse when an engine result is dropped |

## Verification
The bench uses the default parameters: four result bytes, a 16-bit read address, a result window at offset E0h, the status register at E8h and a final tag of 1. With these values a draining loop can be replayed with its tag counting down 4, 3, 2, 1, so reads that are not final and the final read both appear in one sequence. The small window also leaves offsets just outside it where the read mux must return zero. Engine pulses are placed on the same cycle as the final-read swap, to cover both the case where the freed compute bank takes the result and the case where the result is dropped as an overrun.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'b00,
        ST_DONE  = 2'b01
    } bank_stat_e;

    typedef struct packed {
        logic       data_sel;   // physical bank currently owned by the host
        bank_stat_e calc;
        bank_stat_e data;
        logic       overrun;
    } ctl_t;

endpackage

// File: rtl/rbc_addr_dec.sv
module rbc_addr_dec #(
    parameter int ADDR_W    = 16,
    parameter int RES_BYTES = 4,
    parameter int RES_OFS   = 8'hE0,
    parameter int STAT_OFS  = 8'hE8,
    parameter int FINAL_TAG = 1,
    localparam int IDX_W    = (RES_BYTES > 1) ? $clog2(RES_BYTES) : 1,
    localparam int TAG_W    = ADDR_W - 8
) (
    input  logic              host_wr_en,
    input  logic [7:0]        host_wr_ofs,
    input  logic              host_rd_en,
    input  logic [ADDR_W-1:0] host_rd_addr,
    output logic              win_hit,
    output logic [IDX_W-1:0]  win_idx,
    output logic              stat_rd_hit,
    output logic              stat_wr_hit,
    output logic              final_hit
);

    localparam logic [8:0] RES_OFS_X = {1'b0, RES_OFS[7:0]};
    localparam logic [8:0] LIMIT_X   = 9'(RES_BYTES);

    logic [8:0] diff;

    always_comb begin
        diff        = {1'b0, host_rd_addr[7:0]} - RES_OFS_X;
        win_hit     = !diff[8] && (diff < LIMIT_X);
        win_idx     = diff[IDX_W-1:0];
        stat_rd_hit = (host_rd_addr[7:0] == STAT_OFS[7:0]);
        stat_wr_hit = host_wr_en && (host_wr_ofs == STAT_OFS[7:0]);
        final_hit   = host_rd_en && win_hit &&
                      (host_rd_addr[ADDR_W-1:8] == TAG_W'(FINAL_TAG));
    end

endmodule

// File: rtl/rbc_bank_pair.sv
module rbc_bank_pair #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_sel,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] bank_d [2];
    logic [WIDTH-1:0] bank_q [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        always_comb begin
            bank_d[b] = bank_q[b];
            if (wr_en && (wr_sel == 1'(b))) begin
                bank_d[b] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[b] <= '0;
            end else begin
                bank_q[b] <= bank_d[b];
            end
        end
    end

    assign rd_data = rd_sel ? bank_q[1] : bank_q[0];

endmodule

// File: rtl/rbc_result_banks.sv
module rbc_result_banks
    import rbc_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int RES_BYTES = 4,
    parameter int ADDR_W    = 16,
    parameter int RES_OFS   = 8'hE0,
    parameter int STAT_OFS  = 8'hE8,
    parameter int FINAL_TAG = 1,
    localparam int RES_W    = RES_BYTES * BYTE_W,
    localparam int IDX_W    = (RES_BYTES > 1) ? $clog2(RES_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eng_valid,
    input  logic [RES_W-1:0]  eng_result,
    input  logic              host_wr_en,
    input  logic [7:0]        host_wr_ofs,
    input  logic              host_rd_en,
    input  logic [ADDR_W-1:0] host_rd_addr,
    output logic [BYTE_W-1:0] host_rd_data,
    output logic [RES_W-1:0]  res_bytes,
    output logic [1:0]        calc_stat,
    output logic [1:0]        data_stat,
    output logic              overrun
);

    ctl_t             ctl_d, ctl_q;
    logic             swap;
    logic             eng_wr;
    logic             win_hit, stat_rd_hit, stat_wr_hit, final_hit;
    logic [IDX_W-1:0] win_idx;

    rbc_addr_dec #(
        .ADDR_W    (ADDR_W),
        .RES_BYTES (RES_BYTES),
        .RES_OFS   (RES_OFS),
        .STAT_OFS  (STAT_OFS),
        .FINAL_TAG (FINAL_TAG)
    ) i_dec (
        .host_wr_en  (host_wr_en),
        .host_wr_ofs (host_wr_ofs),
        .host_rd_en  (host_rd_en),
        .host_rd_addr(host_rd_addr),
        .win_hit     (win_hit),
        .win_idx     (win_idx),
        .stat_rd_hit (stat_rd_hit),
        .stat_wr_hit (stat_wr_hit),
        .final_hit   (final_hit)
    );

    rbc_bank_pair #(.WIDTH(RES_W)) i_banks (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (eng_wr),
        .wr_sel (~ctl_d.data_sel),
        .wr_data(eng_result),
        .rd_sel (ctl_q.data_sel),
        .rd_data(res_bytes)
    );

    // Next-state: swap decision first, engine capture into the post-swap compute bank.
    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.overrun = 1'b0;
        swap          = 1'b0;
        eng_wr        = 1'b0;

        if (stat_wr_hit && ctl_q.data == ST_EMPTY && ctl_q.calc == ST_DONE) begin
            swap = 1'b1;
        end
        if (final_hit && ctl_q.data == ST_DONE) begin
            if (ctl_q.calc == ST_DONE) begin
                swap = 1'b1;
            end else begin
                ctl_d.data = ST_EMPTY;
            end
        end
        if (swap) begin
            ctl_d.data_sel = ~ctl_q.data_sel;
            ctl_d.data     = ST_DONE;
            ctl_d.calc     = ST_EMPTY;
        end

        if (eng_valid) begin
            if (ctl_d.calc == ST_DONE) begin
                ctl_d.overrun = 1'b1;
            end else begin
                ctl_d.calc = ST_DONE;
                eng_wr     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{data_sel: 1'b0, calc: ST_EMPTY, data: ST_EMPTY, overrun: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        host_rd_data = '0;
        if (stat_rd_hit) begin
            host_rd_data[1:0] = ctl_q.data;
            host_rd_data[3:2] = ctl_q.calc;
        end else if (win_hit) begin
            host_rd_data = res_bytes[win_idx*BYTE_W +: BYTE_W];
        end
    end

    assign calc_stat = ctl_q.calc;
    assign data_stat = ctl_q.data;
    assign overrun   = ctl_q.overrun;

    AST_RESET_EMPTY: assert property (@(posedge clk)
        $rose(rst_n) |-> (calc_stat == 2'b00 && data_stat == 2'b00 && res_bytes == '0)); // R1

    AST_ENGINE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && calc_stat == 2'b00 && !host_wr_en && !host_rd_en)
        |=> (calc_stat == 2'b01 && $stable(res_bytes))); // R2

    AST_WRITE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_hit && data_stat == 2'b00 && calc_stat == 2'b01 && !eng_valid)
        |=> (data_stat == 2'b01 && calc_stat == 2'b00)); // R3

    AST_NO_SWAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_wr_hit && !final_hit) |=> $stable(res_bytes)); // R4

    AST_FINAL_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (final_hit && data_stat == 2'b01 && calc_stat == 2'b00 && !eng_valid)
        |=> (data_stat == 2'b00)); // R5

    AST_FINAL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (final_hit && data_stat == 2'b01 && calc_stat == 2'b01 && !eng_valid)
        |=> (data_stat == 2'b01 && calc_stat == 2'b00)); // R6

    AST_OVERRUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && calc_stat == 2'b01 && data_stat == 2'b01 && !final_hit)
        |=> (overrun && calc_stat == 2'b01)); // R7

    AST_OVERRUN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(eng_valid)); // R7

    AST_EMPTY_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (final_hit && data_stat == 2'b00 && !host_wr_en && !eng_valid)
        |=> ($stable(data_stat) && $stable(calc_stat) && $stable(res_bytes))); // R9

endmodule

// File: tb/test_rbc_result_banks.sv
module test_rbc_result_banks;

    localparam int BYTE_W = 8;
    localparam int NB     = 4;
    localparam int RES_W  = NB * BYTE_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             eng_valid = 1'b0;
    logic [RES_W-1:0] eng_result = '0;
    logic             host_wr_en = 1'b0;
    logic [7:0]       host_wr_ofs = '0;
    logic             host_rd_en = 1'b0;
    logic [15:0]      host_rd_addr = '0;
    logic [7:0]       host_rd_data;
    logic [RES_W-1:0] res_bytes;
    logic [1:0]       calc_stat, data_stat;
    logic             overrun;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    bit        m_cdone = 0, m_ddone = 0, m_ovr = 0;
    bit [31:0] m_calc = 0, m_data = 0;

    always #4 clk = ~clk;

    rbc_result_banks i_rbc_result_banks (
        .clk(clk), .rst_n(rst_n), .eng_valid(eng_valid), .eng_result(eng_result),
        .host_wr_en(host_wr_en), .host_wr_ofs(host_wr_ofs), .host_rd_en(host_rd_en),
        .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data), .res_bytes(res_bytes),
        .calc_stat(calc_stat), .data_stat(data_stat), .overrun(overrun)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int model_rd(input bit [15:0] a);
        int lo = a[7:0];
        if (lo == 8'hE8) return (m_ddone ? 1 : 0) | ((m_cdone ? 1 : 0) << 2);
        if (lo >= 8'hE0 && lo < 8'hE4) return (m_data >> ((lo - 8'hE0) * 8)) & 8'hFF;
        return 0;
    endfunction

    task automatic check_regs(input string req);
        chk(req, "data_stat", data_stat, m_ddone ? 1 : 0);
        chk(req, "calc_stat", calc_stat, m_cdone ? 1 : 0);
        chk(req, "res_bytes", res_bytes, m_data);
        chk(req, "overrun", overrun, m_ovr);
    endtask

    task automatic cyc(input string req, input bit ev, input bit [31:0] er,
                       input bit we, input bit [7:0] wo, input bit re, input bit [15:0] ra);
        bit lo_win, fin, stw, swap;
        @(negedge clk);
        eng_valid = ev; eng_result = er; host_wr_en = we; host_wr_ofs = wo;
        host_rd_en = re; host_rd_addr = ra;
        #1;
        chk(req, "host_rd_data", host_rd_data, model_rd(ra));
        @(posedge clk);
        lo_win = (ra[7:0] >= 8'hE0) && (ra[7:0] < 8'hE4);
        fin    = re && lo_win && (ra[15:8] == 8'd1);
        stw    = we && (wo == 8'hE8);
        swap   = 0;
        if (stw && !m_ddone && m_cdone) swap = 1;
        if (fin && m_ddone) begin
            if (m_cdone) swap = 1; else m_ddone = 0;
        end
        if (swap) begin m_data = m_calc; m_ddone = 1; m_cdone = 0; end
        m_ovr = 0;
        if (ev) begin
            if (m_cdone) m_ovr = 1; else begin m_calc = er; m_cdone = 1; end
        end
        #2;
        check_regs(req);
    endtask

    task automatic idle(input string req);
        cyc(req, 0, 0, 0, 0, 0, 16'h0000);
    endtask

    task automatic drain(input string req);
        for (int k = 0; k < NB; k++) cyc(req, 0, 0, 0, 0, 1, {8'(NB - k), 8'(8'hE0 + k)});
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_regs("R1");
        @(negedge clk); rst_n = 1'b1;
        #3; check_regs("R1");
        idle("R1");

        cyc("R8", 0, 0, 0, 0, 0, 16'h00E8);
        cyc("R8", 0, 0, 0, 0, 0, 16'h00E4);
        cyc("R4", 0, 0, 1, 8'hE8, 0, 16'h0000);          // both empty: ignored
        cyc("R9", 0, 0, 0, 0, 1, 16'h01E3);              // final read while empty
        cyc("R2", 1, 32'hA1B2C3D4, 0, 0, 0, 16'h00E8);
        cyc("R5", 0, 0, 0, 0, 1, 16'h00E0);              // non-final tag
        cyc("R3", 0, 0, 1, 8'hE8, 0, 16'h0000);          // swap
        cyc("R4", 0, 0, 1, 8'hE8, 0, 16'h00E8);          // data done: ignored
        cyc("R4", 0, 0, 1, 8'hE7, 0, 16'h00E1);          // other offset
        drain("R8");
        cyc("R9", 0, 0, 0, 0, 1, 16'h01E0);

        cyc("R2", 1, 32'h11223344, 0, 0, 0, 16'h0000);
        cyc("R3", 1, 32'h55667788, 1, 8'hE8, 0, 16'h00E2); // swap plus capture same cycle
        cyc("R7", 1, 32'hDEADBEEF, 0, 0, 0, 16'h00E8);     // overrun
        idle("R7");
        cyc("R6", 0, 0, 0, 0, 1, 16'h01E3);                // final with waiting result
        cyc("R8", 0, 0, 0, 0, 0, 16'h00E0);
        cyc("R8", 0, 0, 0, 0, 0, 16'h00E3);
        cyc("R2", 1, 32'h0F0E0D0C, 0, 0, 0, 16'h00E8);
        cyc("R7", 1, 32'hCAFEF00D, 0, 0, 1, 16'h01E2);     // swap frees bank, result lands
        cyc("R7", 1, 32'h12345678, 0, 0, 1, 16'h02E1);     // non-final, overrun
        cyc("R6", 0, 0, 0, 0, 1, 16'h01E0);
        cyc("R5", 0, 0, 0, 0, 1, 16'h01E1);
        cyc("R5", 0, 0, 0, 0, 1, 16'h01DF);                // outside window
        idle("R1");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule